// File: doc/BRIEF.md
# Isochronous Transmit Data-Set Flush Manager

This block keeps the bookkeeping for a two-slot transmit queue that feeds an isochronous endpoint. Firmware pushes whole data sets into the queue, the host drains them through IN transactions, and the start-of-frame (SOF) strobe marks frame boundaries. Each queue slot has one bit in a two-bit fill code. At each SOF the block decides whether one stale data set must be thrown away. When it does, it pulses a flush request towards the storage and refreshes a sticky status bit that firmware reads.

Two flush policies are selectable with a mode input. In legacy mode every queued set is readable at once. A flush happens only when both slots are full and no IN token arrived for the endpoint during the whole frame. In framed mode a newly written set stays hidden from the host until the next SOF. Any set that was readable for a full frame and was not read is discarded at the following SOF. When two sets are written into an empty queue within one frame, the older one is dropped at the next SOF. A flush always removes the oldest entry.

Top module: `isoflush_mgr`

## Requirements
- R1: While reset is held at a clock edge, the fill code becomes 00, the host-visible count becomes 0, and both the flush pulse and the flushed status bit become 0.
- R2: Slots are used in turn, starting with slot 0 after reset. A write strobe sets bit k of the fill code for the next free slot k, so writes from empty after reset give 01 and then 11. A write is ignored when the fill code is 11 at that edge.
- R3: An IN-served strobe clears the fill-code bit of the oldest readable set. When no set is readable, the strobe leaves the fill code unchanged.
- R4: In legacy mode (mode input 0) the host-visible count equals the number of ones in the fill code in the cycle after each write.
- R5: In legacy mode, an SOF that finds fill code 11 with no IN-served strobe since the previous SOF flushes the oldest set. After 01 and then 11 have been written, this leaves 10.
- R6: In legacy mode, no flush happens at SOF while at most one set is present.
- R7: In legacy mode, any IN-served strobe during the frame blocks the flush at the closing SOF. This includes a strobe on the SOF cycle itself.
- R8: In framed mode (mode input 1), a set written during a frame adds nothing to the host-visible count until the next SOF.
- R9: In framed mode, a set that was readable during a frame and was not read is flushed at the SOF that closes that frame.
- R10: In framed mode, when two sets are written into an empty queue within one frame, the older one is flushed at the next SOF and the newer one becomes readable.
- R11: An IN-served strobe on an SOF cycle is applied before the flush decision, so the set it reads is never reported as flushed.
- R12: The flushed status bit is reloaded at every SOF, to 1 exactly when that SOF flushed a set. It holds its value between SOFs.
- R13: A flush shows as a one-cycle flush pulse in the cycle after the SOF edge. In the same cycle the fill code loses that set's bit and the flushed bit reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| set_wr | input | 1 | Firmware finished writing one data set |
| in_done | input | 1 | An IN token for this endpoint was served |
| sof | input | 1 | Start-of-frame strobe |
| framed_mode | input | 1 | 0 legacy flush policy, 1 framed flush policy |
| fill_code | output | 2 | Slot occupancy, one bit per slot |
| host_sets | output | 2 | Number of sets the host may read now |
| flush_pulse | output | 1 | One-cycle request to drop the oldest set |
| flushed | output | 1 | Set by the most recent SOF if it flushed |

## Verification
A slot bit that is lost or left standing shows on the fill code in the cycle after the write or read that exposed it. A wrong read or write pointer stays hidden until a flush or read clears the wrong bit. That happens at the latest on the next SOF with two sets queued, where the bench expects 10 after 11. A stuck visibility bit shifts the host count in framed mode at the very next SOF. A missed per-frame IN record turns into a spurious or absent flush pulse at the closing SOF. The bench walks both policies through every strobe combination, comparing against a cycle model.

// File: rtl/isoflush_pkg.sv
// Shared sizes and types for the isochronous flush manager.
package isoflush_pkg;
    localparam int SLOTS = 2;
    localparam int PTR_W = $clog2(SLOTS);
    localparam int CNT_W = $clog2(SLOTS + 1);

    typedef logic [SLOTS-1:0] slot_mask_t;
    typedef logic [PTR_W-1:0] slot_ptr_t;
    typedef logic [CNT_W-1:0] set_cnt_t;

    typedef enum logic {
        MODE_LEGACY = 1'b0,
        MODE_FRAMED = 1'b1
    } flush_mode_e;

    // One-hot mask selecting a single slot.
    function automatic slot_mask_t slot_onehot(input slot_ptr_t p);
        slot_mask_t m;
        m = '0;
        m[p] = 1'b1;
        return m;
    endfunction

    // Number of ones in a slot mask.
    function automatic set_cnt_t slot_count(input slot_mask_t m);
        set_cnt_t c;
        c = '0;
        for (int i = 0; i < SLOTS; i++) begin
            c = c + set_cnt_t'(m[i]);
        end
        return c;
    endfunction
endpackage

// File: rtl/isoflush_frame_monitor.sv
// Remembers whether any IN token was served since the last SOF.
// Assumes strobes are single-cycle; an IN on the SOF cycle belongs
// to the frame that is closing, so the record restarts clear.
module isoflush_frame_monitor (
    input  logic clk,
    input  logic rst_n,
    input  logic in_done,
    input  logic sof,
    output logic in_seen
);
    // Per-frame IN record, cleared on every SOF.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_seen <= 1'b0;
        end else if (sof) begin
            in_seen <= 1'b0;
        end else if (in_done) begin
            in_seen <= 1'b1;
        end
    end
endmodule

// File: rtl/isoflush_decider.sv
// Combinational read and flush decision for one cycle.
// The read is resolved first; the flush decision sees the queue after
// that read. Assumes visibility only ever advances oldest-first.
module isoflush_decider
    import isoflush_pkg::*;
(
    input  flush_mode_e mode,
    input  slot_mask_t  occ,
    input  slot_mask_t  vis,
    input  slot_ptr_t   rd_ptr,
    input  logic        in_done,
    input  logic        sof,
    input  logic        in_seen,
    output logic        take_rd,
    output logic        take_fl
);
    slot_mask_t occ_after_rd;
    slot_ptr_t  ptr_after_rd;
    logic       oldest_ready;
    logic       legacy_fl;
    logic       stale_fl;
    logic       double_fl;

    // Decide whether the host read removes the oldest set.
    always_comb begin
        if (mode == MODE_FRAMED) begin
            oldest_ready = occ[rd_ptr] & vis[rd_ptr];
        end else begin
            oldest_ready = occ[rd_ptr];
        end
        take_rd      = in_done & oldest_ready;
        occ_after_rd = take_rd ? (occ & ~slot_onehot(rd_ptr)) : occ;
        ptr_after_rd = rd_ptr + slot_ptr_t'(take_rd);
    end

    // Decide the SOF flush under the selected policy.
    always_comb begin
        legacy_fl = (occ == '1) & ~in_seen & ~in_done;
        stale_fl  = occ_after_rd[ptr_after_rd] & vis[ptr_after_rd];
        double_fl = (occ_after_rd == '1) & (vis == '0);
        if (mode == MODE_FRAMED) begin
            take_fl = sof & (stale_fl | double_fl);
        end else begin
            take_fl = sof & legacy_fl;
        end
    end
endmodule

// File: rtl/isoflush_slot_bank.sv
// Occupancy, host visibility and ring pointers for the transmit slots.
// A write is accepted only if the queue was not full before the edge.
// Sets present after an SOF's read and flush become visible; a set
// written on an SOF cycle stays hidden until the following SOF.
module isoflush_slot_bank
    import isoflush_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_req,
    input  logic       take_rd,
    input  logic       take_fl,
    input  logic       sof,
    output slot_mask_t occ,
    output slot_mask_t vis,
    output slot_ptr_t  rd_ptr
);
    slot_ptr_t  wr_ptr;
    slot_ptr_t  fl_ptr;
    slot_ptr_t  rd_ptr_nx;
    slot_ptr_t  wr_ptr_nx;
    slot_mask_t rm_mask;
    slot_mask_t wr_mask;
    slot_mask_t occ_nx;
    slot_mask_t vis_nx;
    logic       wr_ok;

    // Removal and insertion masks plus pointer advance.
    always_comb begin
        fl_ptr    = rd_ptr + slot_ptr_t'(take_rd);
        rm_mask   = (take_rd ? slot_onehot(rd_ptr) : '0)
                  | (take_fl ? slot_onehot(fl_ptr) : '0);
        wr_ok     = wr_req & (occ != '1);
        wr_mask   = wr_ok ? slot_onehot(wr_ptr) : '0;
        rd_ptr_nx = fl_ptr + slot_ptr_t'(take_fl);
        wr_ptr_nx = wr_ptr + slot_ptr_t'(wr_ok);
    end

    // Per-slot next state.
    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        logic keep;
        assign keep      = occ[i] & ~rm_mask[i];
        assign occ_nx[i] = keep | wr_mask[i];
        assign vis_nx[i] = wr_mask[i] ? 1'b0 : (sof ? keep : (vis[i] & keep));
    end

    // Slot state registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ    <= '0;
            vis    <= '0;
            rd_ptr <= '0;
            wr_ptr <= '0;
        end else begin
            occ    <= occ_nx;
            vis    <= vis_nx;
            rd_ptr <= rd_ptr_nx;
            wr_ptr <= wr_ptr_nx;
        end
    end
endmodule

// File: rtl/isoflush_status.sv
// Flush pulse towards the storage and the SOF-refreshed flushed flag.
module isoflush_status (
    input  logic clk,
    input  logic rst_n,
    input  logic sof,
    input  logic take_fl,
    output logic flush_pulse,
    output logic flushed
);
    // One-cycle flush pulse and flag reloaded only at SOF.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flush_pulse <= 1'b0;
            flushed     <= 1'b0;
        end else begin
            flush_pulse <= take_fl;
            if (sof) begin
                flushed <= take_fl;
            end
        end
    end
endmodule

// File: rtl/isoflush_mgr.sv
// Top of the isochronous transmit flush manager. Ties the frame
// monitor, decision logic, slot bank and status registers together
// and derives the host-visible count for the active policy.
// Assumes all strobes are synchronous single-cycle pulses.
module isoflush_mgr
    import isoflush_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 set_wr,
    input  logic                 in_done,
    input  logic                 sof,
    input  logic                 framed_mode,
    output logic [SLOTS-1:0]     fill_code,
    output logic [CNT_W-1:0]     host_sets,
    output logic                 flush_pulse,
    output logic                 flushed
);
    flush_mode_e mode;
    slot_mask_t  occ;
    slot_mask_t  vis;
    slot_ptr_t   rd_ptr;
    logic        in_seen;
    logic        take_rd;
    logic        take_fl;

    assign mode = flush_mode_e'(framed_mode);

    isoflush_frame_monitor u_frame (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_done (in_done),
        .sof     (sof),
        .in_seen (in_seen)
    );

    isoflush_decider u_decide (
        .mode    (mode),
        .occ     (occ),
        .vis     (vis),
        .rd_ptr  (rd_ptr),
        .in_done (in_done),
        .sof     (sof),
        .in_seen (in_seen),
        .take_rd (take_rd),
        .take_fl (take_fl)
    );

    isoflush_slot_bank u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_req  (set_wr),
        .take_rd (take_rd),
        .take_fl (take_fl),
        .sof     (sof),
        .occ     (occ),
        .vis     (vis),
        .rd_ptr  (rd_ptr)
    );

    isoflush_status u_stat (
        .clk         (clk),
        .rst_n       (rst_n),
        .sof         (sof),
        .take_fl     (take_fl),
        .flush_pulse (flush_pulse),
        .flushed     (flushed)
    );

    // Outputs: occupancy and the count the host may read now.
    always_comb begin
        fill_code = occ;
        if (mode == MODE_FRAMED) begin
            host_sets = slot_count(occ & vis);
        end else begin
            host_sets = slot_count(occ);
        end
    end
endmodule

// File: rtl/isoflush_checker.sv
// Port-level properties of the flush manager, bound to its top.
module isoflush_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       set_wr,
    input logic       in_done,
    input logic       sof,
    input logic       framed_mode,
    input logic [1:0] fill_code,
    input logic [1:0] host_sets,
    input logic       flush_pulse,
    input logic       flushed
);
    // R1: reset clears every output.
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (fill_code == 2'b00 && host_sets == 2'd0 && !flush_pulse && !flushed));

    // R2: a write into a full queue with no read or SOF changes nothing.
    a_r2_full_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_code == 2'b11 && set_wr && !in_done && !sof) |=> fill_code == 2'b11);

    // R13: a flush pulse only follows an SOF edge.
    a_r13_pulse_after_sof: assert property (@(posedge clk) disable iff (!rst_n)
        flush_pulse |-> $past(sof));

    // R13: the flag reads 1 whenever the pulse is out.
    a_r13_pulse_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        flush_pulse |-> flushed);

    // R12: the flag holds between SOFs.
    a_r12_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !sof |=> $stable(flushed));

    // R6: legacy SOF with at most one set never flushes.
    a_r6_single_no_flush: assert property (@(posedge clk) disable iff (!rst_n)
        (sof && !framed_mode && fill_code != 2'b11) |=> !flush_pulse);

    // R8: framed write into an empty queue stays hidden within the frame.
    a_r8_write_hidden: assert property (@(posedge clk) disable iff (!rst_n)
        (framed_mode && set_wr && !sof && fill_code == 2'b00) |=>
        (host_sets == 2'd0 || !framed_mode));
endmodule

bind isoflush_mgr isoflush_checker u_isoflush_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .set_wr      (set_wr),
    .in_done     (in_done),
    .sof         (sof),
    .framed_mode (framed_mode),
    .fill_code   (fill_code),
    .host_sets   (host_sets),
    .flush_pulse (flush_pulse),
    .flushed     (flushed)
);

// File: tb/test_isoflush_mgr.sv
module test_isoflush_mgr;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       set_wr = 1'b0;
    logic       in_done = 1'b0;
    logic       sof = 1'b0;
    logic       framed_mode = 1'b0;
    logic [1:0] fill_code;
    logic [1:0] host_sets;
    logic       flush_pulse;
    logic       flushed;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // Reference state written from the requirements.
    logic [1:0] m_occ, m_vis;
    logic       m_rp, m_wp, m_seen, m_flag, m_fl;

    always #5 clk = ~clk;

    isoflush_mgr i_isoflush_mgr (
        .clk(clk), .rst_n(rst_n), .set_wr(set_wr), .in_done(in_done),
        .sof(sof), .framed_mode(framed_mode), .fill_code(fill_code),
        .host_sets(host_sets), .flush_pulse(flush_pulse), .flushed(flushed)
    );

    task automatic chk(input string tag, input int got, input int exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic model_reset();
        m_occ = 2'b00; m_vis = 2'b00; m_rp = 1'b0; m_wp = 1'b0;
        m_seen = 1'b0; m_flag = 1'b0; m_fl = 1'b0;
    endtask

    task automatic model_step(input logic wr, input logic rd, input logic s, input logic md);
        logic [1:0] occ_a, vis_a;
        logic rp_a, ready, trd, tfl, wok;
        ready = md ? (m_occ[m_rp] & m_vis[m_rp]) : m_occ[m_rp];
        trd   = rd & ready;
        occ_a = m_occ;
        rp_a  = m_rp;
        if (trd) begin occ_a[m_rp] = 1'b0; rp_a = ~m_rp; end
        tfl = 1'b0;
        if (s) begin
            if (!md) tfl = (m_occ == 2'b11) && !m_seen && !rd;
            else     tfl = (occ_a[rp_a] & m_vis[rp_a]) || (occ_a == 2'b11 && m_vis == 2'b00);
        end
        if (tfl) begin occ_a[rp_a] = 1'b0; rp_a = ~rp_a; end
        vis_a = s ? occ_a : (m_vis & occ_a);
        wok = wr && (m_occ != 2'b11);
        if (wok) begin occ_a[m_wp] = 1'b1; vis_a[m_wp] = 1'b0; m_wp = ~m_wp; end
        m_seen = s ? 1'b0 : (m_seen | rd);
        m_fl   = tfl;
        if (s) m_flag = tfl;
        m_occ = occ_a; m_vis = vis_a; m_rp = rp_a;
    endtask

    // One clock: drive strobes, let the edge pass, advance the model.
    task automatic cyc(input logic wr, input logic rd, input logic s);
        set_wr = wr; in_done = rd; sof = s;
        @(posedge clk);
        model_step(wr, rd, s, framed_mode);
        #1;
        set_wr = 1'b0; in_done = 1'b0; sof = 1'b0;
    endtask

    task automatic cmp_model(input string tag);
        logic [1:0] vm;
        vm = framed_mode ? (m_occ & m_vis) : m_occ;
        chk({tag, " fill"}, int'(fill_code), int'(m_occ));
        chk({tag, " count"}, int'(host_sets), int'(vm[0]) + int'(vm[1]));
        chk({tag, " pulse"}, int'(flush_pulse), int'(m_fl));
        chk({tag, " flag"}, int'(flushed), int'(m_flag));
    endtask

    task automatic do_reset(input logic md);
        framed_mode = md;
        rst_n = 1'b0;
        @(posedge clk); @(posedge clk);
        #1;
        rst_n = 1'b1;
        model_reset();
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: got hang expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] lf;
        // Legacy policy, directed.
        do_reset(1'b0);
        chk("R1 fill", int'(fill_code), 0);
        chk("R1 count", int'(host_sets), 0);
        chk("R1 pulse", int'(flush_pulse), 0);
        chk("R1 flag", int'(flushed), 0);
        cyc(1, 0, 0); chk("R2 first write", int'(fill_code), 1);
        chk("R4 count one", int'(host_sets), 1);
        cyc(1, 0, 0); chk("R2 second write", int'(fill_code), 3);
        chk("R4 count two", int'(host_sets), 2);
        cyc(1, 0, 0); chk("R2 full write ignored", int'(fill_code), 3);
        cyc(0, 0, 1); chk("R5 flush oldest", int'(fill_code), 2);
        chk("R13 pulse", int'(flush_pulse), 1);
        chk("R13 flag", int'(flushed), 1);
        cyc(0, 0, 0); chk("R13 pulse one cycle", int'(flush_pulse), 0);
        chk("R12 flag holds", int'(flushed), 1);
        cyc(0, 0, 1); chk("R6 single kept", int'(fill_code), 2);
        chk("R6 no pulse", int'(flush_pulse), 0);
        chk("R12 flag reloaded", int'(flushed), 0);
        cyc(1, 0, 0); chk("R2 refill", int'(fill_code), 3);
        cyc(0, 1, 0); chk("R3 read oldest", int'(fill_code), 1);
        cyc(1, 0, 0); chk("R2 refill again", int'(fill_code), 3);
        cyc(0, 0, 1); chk("R7 IN blocks flush", int'(flush_pulse), 0);
        chk("R7 fill kept", int'(fill_code), 3);
        cyc(0, 1, 1); chk("R7 IN on SOF", int'(flush_pulse), 0);
        chk("R11 read before decision", int'(fill_code), 2);
        chk("R11 flag", int'(flushed), 0);

        // Framed policy, directed.
        do_reset(1'b1);
        cyc(1, 0, 0); chk("R8 hidden fill", int'(fill_code), 1);
        chk("R8 hidden count", int'(host_sets), 0);
        cyc(0, 1, 0); chk("R3 hidden not read", int'(fill_code), 1);
        cyc(0, 0, 1); chk("R8 visible after SOF", int'(host_sets), 1);
        chk("R8 no flush", int'(flush_pulse), 0);
        cyc(0, 0, 1); chk("R9 stale flushed", int'(fill_code), 0);
        chk("R9 pulse", int'(flush_pulse), 1);
        chk("R9 flag", int'(flushed), 1);
        cyc(1, 0, 0); cyc(1, 0, 0);
        chk("R10 two hidden", int'(fill_code), 3);
        chk("R10 count zero", int'(host_sets), 0);
        cyc(0, 0, 1); chk("R10 older dropped", int'(fill_code), 1);
        chk("R10 newer visible", int'(host_sets), 1);
        chk("R10 pulse", int'(flush_pulse), 1);
        cyc(0, 1, 1); chk("R11 read on SOF", int'(fill_code), 0);
        chk("R11 no pulse", int'(flush_pulse), 0);
        chk("R12 flag cleared", int'(flushed), 0);
        cyc(0, 1, 0); chk("R3 empty read ignored", int'(fill_code), 0);

        // Sweep of all strobe patterns in both policies against the model.
        lf = 16'hACE1;
        for (int md = 0; md < 2; md++) begin
            do_reset(md[0]);
            for (int n = 0; n < 3000; n++) begin
                lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
                cyc(lf[0], lf[1] & lf[5], (lf[4:2] == 3'b000) | (n % 32 == 7));
                cmp_model(md == 0 ? "R5 R7 R12 legacy sweep" : "R9 R10 R11 framed sweep");
            end
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule